// File: doc/BRIEF.md
# Discontinuous-Mode ADC Conversion Sequencer

This block steers an analog-to-digital converter through programmed channel lists, one trigger at a time. Two groups exist. The regular group holds up to sixteen channel numbers. Each regular trigger converts the next slice of `n` entries from that list. The injected group holds up to four entries, and each injected trigger converts exactly one of them. The block keeps its place in each list between triggers. When a list is used up, the next trigger starts again at its first entry.

For every channel, the sequencer presents the channel number and raises a one-cycle start strobe. It then waits for the converter's done pulse, reports one end-of-conversion pulse for that channel, and either starts the next channel of the slice or goes idle. Only one group may run in discontinuous mode at a time, and neither group may do so while automatic injection is enabled. Any other setting raises an error flag. While the flag is up, triggers are dropped.

Top module: `disc_adc_sequencer`

## Requirements
- R1: A regular trigger accepted while idle converts list entries in order, starting at the saved regular position. Entry i sits at bits [5i+4:5i] of `reg_list`. Each conversion shows a one-cycle `conv_start` with `conv_ch` equal to the entry and `conv_inj` low.
- R2: A regular slice holds min(n, L − p) conversions, where n = `disc_n_m1`+1, L = `reg_len_m1`+1 and p is the saved position. The last slice may therefore be short. It never continues into the start of the list.
- R3: Each completed regular conversion raises `reg_eoc` for exactly one cycle, in the cycle after the accepted `conv_done`. This includes conversions in the middle of a slice.
- R4: After the slice that ends at entry L−1, the regular position returns to entry 0.
- R5: An injected trigger converts exactly one entry of `inj_list` (entry j at bits [5j+4:5j]) with `conv_inj` high. `inj_eoc` pulses once when that conversion completes. A trigger for a group whose mode is off has no effect.
- R6: `inj_eos` pulses together with `inj_eoc` only for entry `inj_len_m1`, the last injected entry. The next injected trigger then converts entry 0.
- R7: `cfg_err` is high exactly when both group enables are set, or when `auto_inj_en` is set together with either group enable. While it is high, no trigger is accepted, and both saved positions return to 0.
- R8: A trigger that arrives while a slice is in progress is ignored. It neither lengthens the slice nor queues a new one.
- R9: Clearing the running group's enable aborts the slice and returns that group's position to 0. No end-of-conversion pulse follows for the aborted conversion.
- R10: After reset, `conv_start`, `reg_eoc`, `inj_eoc` and `inj_eos` are low, and both positions are 0.
- R11: A `conv_done` pulse that arrives when no conversion is awaited produces no end-of-conversion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_disc_en | input | 1 | Regular group discontinuous mode on |
| inj_disc_en | input | 1 | Injected group discontinuous mode on |
| auto_inj_en | input | 1 | Automatic injection on (illegal together with either mode) |
| reg_trig | input | 1 | Regular trigger pulse |
| inj_trig | input | 1 | Injected trigger pulse |
| reg_list | input | 80 | Regular channel list, 5 bits per entry |
| reg_len_m1 | input | 4 | Regular list length minus one |
| disc_n_m1 | input | 3 | Slice size n minus one |
| inj_list | input | 20 | Injected channel list, 5 bits per entry |
| inj_len_m1 | input | 2 | Injected list length minus one |
| conv_done | input | 1 | Converter finished the current channel |
| conv_ch | output | 5 | Channel to convert |
| conv_start | output | 1 | One-cycle start strobe |
| conv_inj | output | 1 | Current conversion belongs to the injected group |
| reg_eoc | output | 1 | Regular conversion complete |
| inj_eoc | output | 1 | Injected conversion complete |
| inj_eos | output | 1 | Last injected entry complete |
| cfg_err | output | 1 | Illegal mode combination |

## Verification
The regular list {0,1,2,3,6,7,9,10} is run with n = 3 over four triggers. This shows the difference between a short final slice followed by a wrap to the start, and a slice that wraps partway through. Runs with n = 1 and n = 5 from a position in the middle of the list separate a correct minimum from a fixed slice length. The injected lists of length three and four show whether the end-of-sequence pulse follows the length field and not a fixed entry. Further runs cover triggers during a slice, a stray done pulse, an abort in the middle of a slice, and each illegal mode combination. These runs tell ignored stimulus apart from stimulus that moves the position, because the next accepted trigger must start at the predicted entry.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    GRP_REG = 1'b0,
    GRP_INJ = 1'b1
  } grp_e;

  // Conversions in the slice that starts at position pos of a list with
  // len entries, for slice size n: the smaller of n and what remains.
  function automatic int slice_span(int n, int len, int pos);
    int rest;
    rest = len - pos;
    if (rest < 1) rest = 1;
    return (n < rest) ? n : rest;
  endfunction

  // Position that follows pos in a list of len entries, wrapping to 0.
  function automatic int wrap_next(int pos, int len);
    return (pos + 1 >= len) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/adc_cfg_guard.sv
module adc_cfg_guard (
  input  logic reg_disc_en,
  input  logic inj_disc_en,
  input  logic auto_inj_en,
  output logic cfg_err,
  output logic reg_live,
  output logic inj_live
);

  always_comb begin
    cfg_err  = (reg_disc_en && inj_disc_en) ||
               (auto_inj_en && (reg_disc_en || inj_disc_en));
    reg_live = reg_disc_en && !cfg_err;
    inj_live = inj_disc_en && !cfg_err;
  end

endmodule

// File: rtl/adc_seq_pointer.sv
module adc_seq_pointer
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic          step,
  input  logic [PW-1:0] len_m1,
  output logic [PW-1:0] pos
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (!live) begin
      pos <= '0;
    end else if (step) begin
      pos <= PW'(wrap_next(int'(pos), int'(len_m1) + 1));
    end
  end

endmodule

// File: rtl/adc_list_pick.sv
module adc_list_pick #(
  parameter int DEPTH = 16,
  parameter int CH_W  = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH*CH_W-1:0] list,
  input  logic [PW-1:0]         idx,
  output logic [CH_W-1:0]       ch
);

  logic [CH_W-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign entry[g] = list[g*CH_W +: CH_W];
  end

  assign ch = entry[idx];

endmodule

// File: rtl/disc_adc_sequencer.sv
module disc_adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int REG_DEPTH = 16,
  parameter int INJ_DEPTH = 4,
  parameter int CH_W      = 5,
  parameter int N_MAX     = 8,
  localparam int RPW = $clog2(REG_DEPTH),
  localparam int IPW = $clog2(INJ_DEPTH),
  localparam int NW  = $clog2(N_MAX),
  localparam int LW  = $clog2(N_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_disc_en,
  input  logic                      inj_disc_en,
  input  logic                      auto_inj_en,
  input  logic                      reg_trig,
  input  logic                      inj_trig,
  input  logic [REG_DEPTH*CH_W-1:0] reg_list,
  input  logic [RPW-1:0]            reg_len_m1,
  input  logic [NW-1:0]             disc_n_m1,
  input  logic [INJ_DEPTH*CH_W-1:0] inj_list,
  input  logic [IPW-1:0]            inj_len_m1,
  input  logic                      conv_done,
  output logic [CH_W-1:0]           conv_ch,
  output logic                      conv_start,
  output logic                      conv_inj,
  output logic                      reg_eoc,
  output logic                      inj_eoc,
  output logic                      inj_eos,
  output logic                      cfg_err
);

  // Named internal events, also used by the bound checker.
  logic reg_live, inj_live;
  logic busy, start_q;
  grp_e grp_q;
  logic [LW-1:0] left_q;
  logic [LW-1:0] first_span;
  logic trig_accept, done_accept, abort, reg_step, inj_step;
  logic [RPW-1:0] reg_pos;
  logic [IPW-1:0] inj_pos;
  logic [CH_W-1:0] reg_ch, inj_ch;

  adc_cfg_guard u_guard (
    .reg_disc_en (reg_disc_en),
    .inj_disc_en (inj_disc_en),
    .auto_inj_en (auto_inj_en),
    .cfg_err     (cfg_err),
    .reg_live    (reg_live),
    .inj_live    (inj_live)
  );

  always_comb begin
    trig_accept = !busy && ((reg_live && reg_trig) || (inj_live && inj_trig));
    abort       = busy && ((grp_q == GRP_REG) ? !reg_live : !inj_live);
    done_accept = busy && !start_q && conv_done && !abort;
    reg_step    = done_accept && (grp_q == GRP_REG);
    inj_step    = done_accept && (grp_q == GRP_INJ);
    first_span  = LW'(slice_span(int'(disc_n_m1) + 1, int'(reg_len_m1) + 1,
                                 int'(reg_pos)));
  end

  adc_seq_pointer #(.DEPTH(REG_DEPTH)) u_reg_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (reg_live),
    .step   (reg_step),
    .len_m1 (reg_len_m1),
    .pos    (reg_pos)
  );

  adc_seq_pointer #(.DEPTH(INJ_DEPTH)) u_inj_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (inj_live),
    .step   (inj_step),
    .len_m1 (inj_len_m1),
    .pos    (inj_pos)
  );

  adc_list_pick #(.DEPTH(REG_DEPTH), .CH_W(CH_W)) u_reg_pick (
    .list (reg_list),
    .idx  (reg_pos),
    .ch   (reg_ch)
  );

  adc_list_pick #(.DEPTH(INJ_DEPTH), .CH_W(CH_W)) u_inj_pick (
    .list (inj_list),
    .idx  (inj_pos),
    .ch   (inj_ch)
  );

  // Slice control: one start per channel, then wait for done.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      start_q <= 1'b0;
      grp_q   <= GRP_REG;
      left_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (abort) begin
        busy   <= 1'b0;
        left_q <= '0;
      end else if (trig_accept) begin
        busy    <= 1'b1;
        start_q <= 1'b1;
        grp_q   <= inj_live ? GRP_INJ : GRP_REG;
        left_q  <= inj_live ? LW'(1) : first_span;
      end else if (done_accept) begin
        if (left_q > LW'(1)) begin
          left_q  <= left_q - LW'(1);
          start_q <= 1'b1;
        end else begin
          busy   <= 1'b0;
          left_q <= '0;
        end
      end
    end
  end

  // Completion events, one cycle after the accepted done.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_eoc <= 1'b0;
      inj_eoc <= 1'b0;
      inj_eos <= 1'b0;
    end else begin
      reg_eoc <= reg_step;
      inj_eoc <= inj_step;
      inj_eos <= inj_step && (inj_pos >= inj_len_m1);
    end
  end

  assign conv_start = start_q;
  assign conv_inj   = (grp_q == GRP_INJ);
  assign conv_ch    = (grp_q == GRP_INJ) ? inj_ch : reg_ch;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic conv_inj,
  input logic conv_done,
  input logic reg_eoc,
  input logic inj_eoc,
  input logic inj_eos,
  input logic cfg_err,
  input logic reg_disc_en,
  input logic inj_disc_en,
  input logic trig_accept,
  input logic done_accept,
  input logic busy
);

  a_r1_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r3_eoc_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_eoc || inj_eoc) |-> $past(done_accept && conv_done));

  a_r5_single_eoc_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_eoc, inj_eoc}));

  a_r5_inj_eoc_group: assert property (@(posedge clk) disable iff (!rst_n)
    inj_eoc |-> $past(conv_inj));

  a_r6_eos_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    inj_eos |-> inj_eoc);

  a_r7_err_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !trig_accept);

  a_r7_err_stops_start: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !conv_start);

  a_r8_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !trig_accept);

  a_r9_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_disc_en && !inj_disc_en) |=> !conv_start);

endmodule

bind disc_adc_sequencer adc_seq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_start  (conv_start),
  .conv_inj    (conv_inj),
  .conv_done   (conv_done),
  .reg_eoc     (reg_eoc),
  .inj_eoc     (inj_eoc),
  .inj_eos     (inj_eos),
  .cfg_err     (cfg_err),
  .reg_disc_en (reg_disc_en),
  .inj_disc_en (inj_disc_en),
  .trig_accept (trig_accept),
  .done_accept (done_accept),
  .busy        (busy)
);

// File: tb/tb_disc_adc_sequencer.sv
module tb_disc_adc_sequencer;
  localparam int DEPTH = 16, IDEPTH = 4, CHW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, reg_disc_en, inj_disc_en, auto_inj_en, reg_trig, inj_trig;
  logic [DEPTH*CHW-1:0] reg_list;
  logic [IDEPTH*CHW-1:0] inj_list;
  logic [3:0] reg_len_m1;
  logic [2:0] disc_n_m1;
  logic [1:0] inj_len_m1;
  logic conv_done, model_done, stray_done;
  logic [CHW-1:0] conv_ch;
  logic conv_start, conv_inj, reg_eoc, inj_eoc, inj_eos, cfg_err;

  assign conv_done = model_done | stray_done;

  disc_adc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .reg_disc_en(reg_disc_en), .inj_disc_en(inj_disc_en),
    .auto_inj_en(auto_inj_en), .reg_trig(reg_trig), .inj_trig(inj_trig),
    .reg_list(reg_list), .reg_len_m1(reg_len_m1), .disc_n_m1(disc_n_m1),
    .inj_list(inj_list), .inj_len_m1(inj_len_m1), .conv_done(conv_done),
    .conv_ch(conv_ch), .conv_start(conv_start), .conv_inj(conv_inj),
    .reg_eoc(reg_eoc), .inj_eoc(inj_eoc), .inj_eos(inj_eos), .cfg_err(cfg_err)
  );

  int checks = 0, fails = 0;
  int rlist[DEPTH];
  int ilist[IDEPTH];
  int rlen = 1, nval = 1, ilen = 1, rpos = 0, ipos = 0, lat = 2;
  bit m_ren = 0, m_ien = 0, m_auto = 0;
  int exp_start_q[$];
  int exp_done_q[$];

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit legal();
    return !(m_ren && m_ien) && !(m_auto && (m_ren || m_ien));
  endfunction

  // Converter model: answers each start after lat cycles.
  initial begin
    int cnt;
    cnt = 0;
    model_done = 1'b0;
    forever begin
      @(negedge clk);
      model_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) model_done = 1'b1;
      end
      if (conv_start) cnt = lat;
    end
  end

  // Every-cycle comparison against the expected event queues.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (conv_start) begin
          if (exp_start_q.size() == 0)
            check(1'b0, "R8 unexpected start", int'(conv_ch), -1);
          else begin
            int e, a;
            e = exp_start_q.pop_front();
            a = (conv_inj ? 100 : 0) + int'(conv_ch);
            check(a == e, (e >= 100) ? "R5 injected channel" : "R1 regular channel", a, e);
          end
        end
        if (reg_eoc || inj_eoc) begin
          int a;
          a = (inj_eoc ? 10 : 0) + (inj_eos ? 1 : 0) + ((reg_eoc && inj_eoc) ? 100 : 0);
          if (exp_done_q.size() == 0)
            check(1'b0, "R11 unexpected eoc", a, -1);
          else begin
            int e;
            e = exp_done_q.pop_front();
            check(a == e, (e >= 10) ? "R6 injected eoc/eos" : "R3 regular eoc", a, e);
          end
        end else if (inj_eos) begin
          check(1'b0, "R6 eos without eoc", 1, 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic apply_lists();
    for (int k = 0; k < DEPTH; k++) reg_list[k*CHW +: CHW] = CHW'(rlist[k]);
    for (int k = 0; k < IDEPTH; k++) inj_list[k*CHW +: CHW] = CHW'(ilist[k]);
    reg_len_m1 = 4'(rlen - 1);
    disc_n_m1  = 3'(nval - 1);
    inj_len_m1 = 2'(ilen - 1);
  endtask

  task automatic set_cfg(bit r, bit i, bit a);
    @(negedge clk);
    reg_disc_en = r; inj_disc_en = i; auto_inj_en = a;
    m_ren = r; m_ien = i; m_auto = a;
    if (!r || !legal()) rpos = 0;
    if (!i || !legal()) ipos = 0;
    repeat (2) @(negedge clk);
    check(cfg_err == !legal(), "R7 error flag", int'(cfg_err), int'(!legal()));
  endtask

  task automatic plan_reg();
    int cnt;
    cnt = (nval < rlen - rpos) ? nval : rlen - rpos;
    for (int k = 0; k < cnt; k++) begin
      exp_start_q.push_back(rlist[rpos]);
      exp_done_q.push_back(0);
      rpos = (rpos + 1 >= rlen) ? 0 : rpos + 1;
    end
  endtask

  task automatic plan_inj();
    exp_start_q.push_back(100 + ilist[ipos]);
    exp_done_q.push_back(10 + ((ipos == ilen - 1) ? 1 : 0));
    ipos = (ipos + 1 >= ilen) ? 0 : ipos + 1;
  endtask

  task automatic pulse(bit inj);
    @(negedge clk);
    if (inj) inj_trig = 1'b1; else reg_trig = 1'b1;
    @(negedge clk);
    inj_trig = 1'b0; reg_trig = 1'b0;
  endtask

  task automatic settle(string req);
    int t;
    t = 0;
    while ((exp_start_q.size() != 0 || exp_done_q.size() != 0) && t < 300) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(exp_start_q.size() == 0 && exp_done_q.size() == 0, req,
          exp_start_q.size() + exp_done_q.size(), 0);
  endtask

  task automatic fire(bit inj, string req);
    if (legal() && (inj ? m_ien : m_ren)) begin
      if (inj) plan_inj(); else plan_reg();
    end
    pulse(inj);
    settle(req);
  endtask

  initial begin
    int t;
    rst_n = 1'b0; reg_disc_en = 0; inj_disc_en = 0; auto_inj_en = 0;
    reg_trig = 0; inj_trig = 0; stray_done = 0;
    reg_list = '0; inj_list = '0; reg_len_m1 = '0; disc_n_m1 = '0; inj_len_m1 = '0;
    foreach (rlist[k]) rlist[k] = 0;
    foreach (ilist[k]) ilist[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!conv_start && !reg_eoc && !inj_eoc && !inj_eos, "R10 reset outputs",
          int'({conv_start, reg_eoc, inj_eoc, inj_eos}), 0);

    // Regular list 0,1,2,3,6,7,9,10 with n = 3: slices, short tail, wrap.
    rlist[0] = 0; rlist[1] = 1; rlist[2] = 2; rlist[3] = 3;
    rlist[4] = 6; rlist[5] = 7; rlist[6] = 9; rlist[7] = 10;
    rlen = 8; nval = 3; ilist[0] = 1; ilist[1] = 2; ilist[2] = 3; ilen = 3;
    apply_lists();
    set_cfg(1, 0, 0);
    fire(0, "R1 first slice done");
    fire(0, "R1 second slice done");
    fire(0, "R2 short final slice done");
    fire(0, "R4 wrap to first slice");

    // Other slice sizes from a mid-list position.
    lat = 1; nval = 1; apply_lists();
    fire(0, "R2 single-entry slice");
    fire(0, "R2 single-entry slice again");
    nval = 5; apply_lists();
    fire(0, "R2 clipped slice n=5");
    fire(0, "R4 full slice after wrap");

    // Trigger during a slice is ignored.
    lat = 6; nval = 3; apply_lists();
    plan_reg();
    pulse(0);
    repeat (3) @(negedge clk);
    pulse(0);
    settle("R8 busy trigger ignored");

    // Stray done while idle.
    @(negedge clk); stray_done = 1'b1;
    @(negedge clk); stray_done = 1'b0;
    check(!reg_eoc && !inj_eoc, "R11 stray done no eoc", int'({reg_eoc, inj_eoc}), 0);
    @(negedge clk);
    check(!reg_eoc && !inj_eoc, "R11 stray done no eoc later", int'({reg_eoc, inj_eoc}), 0);

    // Abort in mid-slice by disabling the group.
    lat = 5;
    exp_start_q.push_back(rlist[rpos]);
    pulse(0);
    t = 0;
    while (!conv_start && t < 20) begin @(negedge clk); t++; end
    @(negedge clk);
    reg_disc_en = 1'b0; m_ren = 0; rpos = 0;
    repeat (12) @(negedge clk);
    check(exp_start_q.size() == 0 && !reg_eoc, "R9 abort leaves no events",
          exp_start_q.size(), 0);
    set_cfg(1, 0, 0);
    lat = 2;
    fire(0, "R9 restart at entry 0");

    // Injected mode, length 3 then 4.
    set_cfg(0, 1, 0);
    fire(0, "R5 regular trigger ignored in injected mode");
    for (int k = 0; k < 4; k++) fire(1, "R6 injected length 3");
    ilist[0] = 4; ilist[1] = 5; ilist[2] = 6; ilist[3] = 7; ilen = 4;
    apply_lists();
    set_cfg(0, 0, 0);
    set_cfg(0, 1, 0);
    for (int k = 0; k < 5; k++) fire(1, "R6 injected length 4");

    // Illegal combinations.
    set_cfg(1, 1, 0);
    fire(0, "R7 regular ignored on error");
    fire(1, "R7 injected ignored on error");
    set_cfg(1, 0, 1);
    fire(0, "R7 regular ignored with auto injection");
    set_cfg(0, 1, 1);
    fire(1, "R7 injected ignored with auto injection");
    set_cfg(1, 0, 0);
    fire(0, "R7 regular restarts at entry 0");
    set_cfg(0, 1, 0);
    fire(1, "R7 injected restarts at entry 0");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule